// File: doc/BRIEF.md
# Multi-Mode ADC Serial Readout Controller

This block is the digital half of a 12-bit sampling converter. A rising edge on the convert-start input freezes the input (hold), latches the sample word offered by the analog stand-in, and times the conversion with a system-clock counter. When the count runs out, a one-cycle end-of-conversion strobe returns the block to tracking, opens a timed acquisition window, and arms a serial readout.

The result leaves over three wires: an active-low frame signal, a serial clock and a data line. Two static pins pick one of four framing modes. A `frame16_sel`/`contclk_sel` value of 00 selects mode A, 01 mode B, 10 mode C and 11 mode D. Mode A drives its own burst clock. Modes B and D take a continuous external clock, and mode C takes an external burst. A polarity input sets the serial clock's idle level. The edge that leaves the idle level is the data edge, on which the data line is updated. The edge that returns to idle is the return edge, on which frame timing is counted. Return edges are counted from the end-of-conversion strobe.

Top module: `adc_serial_readout`

## Requirements
- R1: A rising edge of `conv_start` while the block is idle latches `sample_in` and drives `tracking` low for exactly CONV_A_CYC clock cycles in mode A, or CONV_LONG_CYC cycles in modes B, C and D.
- R2: At the end of a conversion, `eoc` is high for exactly one cycle. That is the first cycle in which `tracking` is high again, and from that cycle `acquiring` is high for exactly ACQ_CYC cycles.
- R3: In mode A the block emits 14 clock pulses on `sclk_out`. `frame_n` falls on the 2nd return edge. The 12 result bits appear on the data edges of pulses 3 to 14. `frame_n` rises on the 14th return edge, and `sclk_out` ends at its idle level.
- R4: In mode B, `frame_n` falls on the first return edge of `ext_sclk` after end of conversion. The next 14 data edges carry 2 zero bits and then the 12 result bits. `frame_n` rises on the 15th return edge.
- R5: In mode C, `frame_n` falls at end of conversion, before any clock edge. The 16 data edges carry 4 zero bits and then the result. `frame_n` rises on the 16th return edge.
- R6: In mode D, `frame_n` falls on the first return edge. The 16 data edges that follow carry 4 zero bits and then the result. `frame_n` rises on the 17th return edge.
- R7: The result is sent MSB first, leading bits are 0, and `sdata` is 0 whenever `frame_n` is high.
- R8: With `idle_high` = 1 the data edge is the falling edge. With `idle_high` = 0 the edge roles swap and the same framing holds.
- R9: A `conv_start` rising edge that arrives during a conversion, an acquisition window or an unfinished readout does not start a conversion and does not change the latched sample. It sets `overrun`, which stays set until reset.
- R10: After reset, `frame_n`=1, `sdata`=0, `tracking`=1, `acquiring`=0, `eoc`=0, `overrun`=0 and `sclk_out` equals `idle_high`.
- R11: Outside a mode A burst, `sclk_out` rests at the level given by `idle_high`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_start | input | 1 | Convert start; a rising edge begins a conversion |
| frame16_sel | input | 1 | 1 selects a 16-clock frame, 0 a 14-clock frame |
| contclk_sel | input | 1 | 1 selects a continuous external clock, 0 a burst clock |
| idle_high | input | 1 | Idle level of the serial clock |
| ext_sclk | input | 1 | External serial clock (modes B, C, D) |
| sample_in | input | DATA_W | Sample word from the analog stand-in |
| frame_n | output | 1 | Active-low frame |
| sclk_out | output | 1 | Generated burst clock (mode A) |
| sdata | output | 1 | Serial data, MSB first |
| tracking | output | 1 | 1 while tracking, 0 during conversion |
| acquiring | output | 1 | Acquisition window after conversion |
| eoc | output | 1 | One-cycle end-of-conversion strobe |
| overrun | output | 1 | Sticky flag for a rejected convert start |

## Verification
The assertions watch, on every cycle, the properties that hold in every mode. These are: the strobe follows the end of a conversion and lasts one cycle, the overrun flag is sticky, the data line is quiet outside a frame, no frame is open during a conversion, and a mode A burst ends at the idle level. Only the bench scenarios can show the per-mode edge counts at which the frame opens and closes, the position of each result bit, the exact conversion and acquisition lengths, and the swap of edge roles under both polarities. The same holds for showing that a rejected start leaves both the timing and the latched word untouched.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
   // Encoding is {frame16_sel, contclk_sel}
   typedef enum logic [1:0] {
      MODE_A = 2'b00,
      MODE_B = 2'b01,
      MODE_C = 2'b10,
      MODE_D = 2'b11
   } rd_mode_e;
endpackage

// File: rtl/adc_conv_timer.sv
module adc_conv_timer
   import adc_rd_pkg::*;
#(
   parameter int DATA_W        = 12,
   parameter int CONV_A_CYC    = 280,
   parameter int CONV_LONG_CYC = 320,
   parameter int ACQ_CYC       = 60
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_rise,
   input  logic              long_conv,
   input  logic              rd_busy,
   input  logic [DATA_W-1:0] sample_in,
   output logic [DATA_W-1:0] hold_word,
   output logic              converting,
   output logic              acquiring,
   output logic              eoc,
   output logic              overrun
);
   localparam int CONV_MAX = (CONV_A_CYC > CONV_LONG_CYC) ? CONV_A_CYC : CONV_LONG_CYC;
   localparam int CW = $clog2(CONV_MAX + 1);
   localparam int AW = $clog2(ACQ_CYC + 1);

   if (CONV_A_CYC < 2 || CONV_LONG_CYC < 2 || ACQ_CYC < 1) begin : g_bad_timing
      $error("conversion lengths must be >= 2 and acquisition >= 1");
   end

   logic [CW-1:0] conv_cnt;
   logic [AW-1:0] acq_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         converting <= 1'b0;
         acquiring  <= 1'b0;
         eoc        <= 1'b0;
         overrun    <= 1'b0;
         conv_cnt   <= '0;
         acq_cnt    <= '0;
         hold_word  <= '0;
      end else begin
         eoc <= 1'b0;
         if (start_rise) begin
            if (converting || acquiring || rd_busy) begin
               overrun <= 1'b1;
            end else begin
               converting <= 1'b1;
               hold_word  <= sample_in;
               conv_cnt   <= long_conv ? CW'(CONV_LONG_CYC - 1) : CW'(CONV_A_CYC - 1);
            end
         end
         if (converting) begin
            if (conv_cnt == '0) begin
               converting <= 1'b0;
               eoc        <= 1'b1;
               acquiring  <= 1'b1;
               acq_cnt    <= AW'(ACQ_CYC - 1);
            end else begin
               conv_cnt <= conv_cnt - 1'b1;
            end
         end
         if (acquiring) begin
            if (acq_cnt == '0) acquiring <= 1'b0;
            else               acq_cnt   <= acq_cnt - 1'b1;
         end
      end
   end

   p_eoc_follows_conv_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(converting) |-> (eoc && acquiring));
   p_eoc_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      eoc |=> !eoc);
   p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(overrun) |-> overrun);
endmodule

// File: rtl/adc_burst_gen.sv
module adc_burst_gen #(
   parameter int SCLK_HALF = 5,
   parameter int PULSES    = 14
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic idle_high,
   output logic sclk
);
   localparam int HW = $clog2(SCLK_HALF + 1);
   localparam int TW = $clog2(2 * PULSES + 1);

   if (SCLK_HALF < 2 || PULSES < 1) begin : g_bad_burst
      $error("burst half period must be >= 2 and pulse count >= 1");
   end

   logic          run;
   logic [HW-1:0] half_cnt;
   logic [TW-1:0] tog_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run      <= 1'b0;
         sclk     <= idle_high;
         half_cnt <= '0;
         tog_cnt  <= '0;
      end else if (!run) begin
         sclk <= idle_high;
         if (start) begin
            run      <= 1'b1;
            half_cnt <= HW'(SCLK_HALF - 1);
            tog_cnt  <= '0;
         end
      end else if (half_cnt == '0) begin
         sclk     <= ~sclk;
         half_cnt <= HW'(SCLK_HALF - 1);
         if (tog_cnt == TW'(2 * PULSES - 1)) run <= 1'b0;
         else                                tog_cnt <= tog_cnt + 1'b1;
      end else begin
         half_cnt <= half_cnt - 1'b1;
      end
   end

   p_burst_ends_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(run) |-> (sclk == idle_high));
endmodule

// File: rtl/adc_frame_shifter.sv
module adc_frame_shifter
   import adc_rd_pkg::*;
#(
   parameter int DATA_W      = 12,
   parameter int SHORT_FRAME = 14,
   parameter int LONG_FRAME  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  rd_mode_e          mode,
   input  logic              idle_high,
   input  logic              sclk_src,
   input  logic              eoc,
   input  logic [DATA_W-1:0] word_in,
   output logic              frame_n,
   output logic              sdata,
   output logic              busy
);
   localparam int CW = $clog2(LONG_FRAME + 2);

   logic [CW-1:0]     open_at, close_at, lead, ret_cnt, dat_cnt;
   logic [DATA_W-1:0] shreg;
   logic              src_q, armed, in_frame, ret_edge, dat_edge;

   // Per-mode frame geometry, counted in return edges
   always_comb begin
      unique case (mode)
         MODE_A: begin
            open_at = CW'(SHORT_FRAME - DATA_W); close_at = CW'(SHORT_FRAME);
            lead = '0;
         end
         MODE_B: begin
            open_at = CW'(1); close_at = CW'(SHORT_FRAME + 1);
            lead = CW'(SHORT_FRAME - DATA_W);
         end
         MODE_C: begin
            open_at = '0; close_at = CW'(LONG_FRAME);
            lead = CW'(LONG_FRAME - DATA_W);
         end
         default: begin
            open_at = CW'(1); close_at = CW'(LONG_FRAME + 1);
            lead = CW'(LONG_FRAME - DATA_W);
         end
      endcase
   end

   assign ret_edge = (sclk_src != src_q) && (sclk_src == idle_high);
   assign dat_edge = (sclk_src != src_q) && (sclk_src != idle_high);
   assign frame_n  = ~in_frame;
   assign busy     = armed | in_frame;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src_q    <= idle_high;
         armed    <= 1'b0;
         in_frame <= 1'b0;
         sdata    <= 1'b0;
         ret_cnt  <= '0;
         dat_cnt  <= '0;
         shreg    <= '0;
      end else begin
         src_q <= sclk_src;
         if (!armed && !in_frame) begin
            if (eoc) begin
               ret_cnt <= '0;
               dat_cnt <= '0;
               shreg   <= word_in;
               if (open_at == '0) in_frame <= 1'b1;
               else               armed    <= 1'b1;
            end
         end else if (ret_edge) begin
            ret_cnt <= ret_cnt + 1'b1;
            if (armed && (ret_cnt + CW'(1) == open_at)) begin
               armed    <= 1'b0;
               in_frame <= 1'b1;
            end
            if (in_frame && (ret_cnt + CW'(1) == close_at)) begin
               in_frame <= 1'b0;
               sdata    <= 1'b0;
            end
         end else if (dat_edge && in_frame) begin
            dat_cnt <= dat_cnt + 1'b1;
            if (dat_cnt >= lead) begin
               sdata <= shreg[DATA_W-1];
               shreg <= {shreg[DATA_W-2:0], 1'b0};
            end else begin
               sdata <= 1'b0;
            end
         end
      end
   end

   p_quiet_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
      frame_n |-> !sdata);
endmodule

// File: rtl/adc_serial_readout.sv
module adc_serial_readout
   import adc_rd_pkg::*;
#(
   parameter int DATA_W        = 12,
   parameter int SHORT_FRAME   = 14,
   parameter int LONG_FRAME    = 16,
   parameter int CONV_A_CYC    = 280,
   parameter int CONV_LONG_CYC = 320,
   parameter int ACQ_CYC       = 60,
   parameter int SCLK_HALF     = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              conv_start,
   input  logic              frame16_sel,
   input  logic              contclk_sel,
   input  logic              idle_high,
   input  logic              ext_sclk,
   input  logic [DATA_W-1:0] sample_in,
   output logic              frame_n,
   output logic              sclk_out,
   output logic              sdata,
   output logic              tracking,
   output logic              acquiring,
   output logic              eoc,
   output logic              overrun
);
   if (SHORT_FRAME <= DATA_W || LONG_FRAME <= SHORT_FRAME) begin : g_bad_frame
      $error("frames must satisfy DATA_W < SHORT_FRAME < LONG_FRAME");
   end

   rd_mode_e          mode;
   logic              conv_q, start_rise, converting, rd_busy, gen_sclk, sclk_src;
   logic [DATA_W-1:0] hold_word;

   assign mode       = rd_mode_e'({frame16_sel, contclk_sel});
   assign start_rise = conv_start & ~conv_q;
   assign sclk_src   = (mode == MODE_A) ? gen_sclk : ext_sclk;
   assign sclk_out   = gen_sclk;
   assign tracking   = ~converting;

   always_ff @(posedge clk) begin
      if (!rst_n) conv_q <= 1'b0;
      else        conv_q <= conv_start;
   end

   adc_conv_timer #(
      .DATA_W(DATA_W), .CONV_A_CYC(CONV_A_CYC),
      .CONV_LONG_CYC(CONV_LONG_CYC), .ACQ_CYC(ACQ_CYC)
   ) u_timer (
      .clk(clk), .rst_n(rst_n), .start_rise(start_rise),
      .long_conv(mode != MODE_A), .rd_busy(rd_busy), .sample_in(sample_in),
      .hold_word(hold_word), .converting(converting), .acquiring(acquiring),
      .eoc(eoc), .overrun(overrun)
   );

   adc_burst_gen #(.SCLK_HALF(SCLK_HALF), .PULSES(SHORT_FRAME)) u_burst (
      .clk(clk), .rst_n(rst_n), .start(eoc && (mode == MODE_A)),
      .idle_high(idle_high), .sclk(gen_sclk)
   );

   adc_frame_shifter #(
      .DATA_W(DATA_W), .SHORT_FRAME(SHORT_FRAME), .LONG_FRAME(LONG_FRAME)
   ) u_shift (
      .clk(clk), .rst_n(rst_n), .mode(mode), .idle_high(idle_high),
      .sclk_src(sclk_src), .eoc(eoc), .word_in(hold_word),
      .frame_n(frame_n), .sdata(sdata), .busy(rd_busy)
   );

   p_no_frame_in_conv_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_n |-> tracking);
endmodule

// File: tb/adc_serial_readout_bench.sv
module adc_serial_readout_bench;
   localparam int DATA_W = 12;
   localparam int CONV_A = 280;
   localparam int CONV_L = 320;
   localparam int ACQ    = 60;

   // {frame16_sel, contclk_sel, idle_high, sample}
   localparam logic [14:0] VECS [8] = '{
      15'h1A5C, 15'h33F1, 15'h5800, 15'h7FFF,
      15'h0001, 15'h27E6, 15'h45A5, 15'h6C3A
   };

   logic clk = 1'b0, rst_n = 1'b0, conv_start = 1'b0;
   logic frame16_sel = 1'b0, contclk_sel = 1'b0, idle_high = 1'b1, ext_sclk = 1'b1;
   logic [DATA_W-1:0] sample_in = '0;
   logic frame_n, sclk_out, sdata, tracking, acquiring, eoc, overrun;
   int n_run = 0, n_fail = 0;

   always #2.5 clk = ~clk;

   adc_serial_readout u_adc_serial_readout (
      .clk(clk), .rst_n(rst_n), .conv_start(conv_start),
      .frame16_sel(frame16_sel), .contclk_sel(contclk_sel), .idle_high(idle_high),
      .ext_sclk(ext_sclk), .sample_in(sample_in), .frame_n(frame_n),
      .sclk_out(sclk_out), .sdata(sdata), .tracking(tracking),
      .acquiring(acquiring), .eoc(eoc), .overrun(overrun)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic string mode_req(input int m, input logic idl);
      string t;
      t = (m == 0) ? "R3" : (m == 1) ? "R4" : (m == 2) ? "R5" : "R6";
      return idl ? t : {t, "/R8"};
   endfunction

   // Pulse convert start; optionally a second pulse at cycle glitch_at. Returns low cycles.
   task automatic run_conv(input logic [DATA_W-1:0] smp, input int glitch_at, output int n);
      @(negedge clk);
      sample_in  = smp;
      conv_start = 1'b1;
      @(posedge clk); #1;
      conv_start = 1'b0;
      n = 0;
      while (tracking == 1'b0 && n < 5000) begin
         n++;
         if (n == glitch_at) begin conv_start = 1'b1; sample_in = ~smp; end
         if (n == glitch_at + 1) conv_start = 1'b0;
         @(posedge clk); #1;
      end
   endtask

   task automatic run_frame(input int m, input logic idl, input logic [DATA_W-1:0] smp);
      int asrt, rel, lead, nedges, lc, dc, idx, expb;
      logic infr;
      string rq;
      rq   = mode_req(m, idl);
      asrt = (m == 0) ? 2 : (m == 2) ? 0 : 1;
      rel  = (m == 0) ? 14 : (m == 1) ? 15 : (m == 2) ? 16 : 17;
      lead = (m == 0) ? 0 : (m == 1) ? 2 : 4;
      nedges = (m == 0) ? 28 : (m == 2) ? 32 : 2 * rel + 2;
      repeat (2) @(posedge clk); #1;
      infr = (asrt == 0);
      chk(rq, "frame before first edge", int'(frame_n), int'(!infr));
      lc = 0; dc = 0;
      for (int e = 1; e <= nedges; e++) begin
         if (m == 0) @(sclk_out);
         else begin @(negedge clk); ext_sclk = ~ext_sclk; end
         repeat (3) @(posedge clk); #1;
         if (e % 2 == 0) begin
            lc++;
            if (!infr && lc == asrt) infr = 1'b1;
            else if (infr && lc == rel) infr = 1'b0;
         end else if (infr) begin
            dc++;
            idx  = DATA_W - 1 - (dc - lead - 1);
            expb = (dc <= lead) ? 0 : int'(smp[idx]);
            chk({rq, "/R7"}, $sformatf("bit at data edge %0d", dc), int'(sdata), expb);
         end
         if (m == 0 && e % 2 == 1)
            chk({rq, "/R3"}, "burst clock left idle", int'(sclk_out), int'(!idl));
         chk(rq, $sformatf("frame after edge %0d", e), int'(frame_n), int'(!infr));
         if (!infr) chk("R7", "data quiet outside frame", int'(sdata), 0);
      end
      repeat (8) @(posedge clk); #1;
      chk("R11", "sclk_out at idle after frame", int'(sclk_out), int'(idl));
      chk(rq, "frame closed", int'(frame_n), 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      int n, m, a;
      logic idl;
      logic [DATA_W-1:0] smp;
      repeat (4) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      @(posedge clk); #1;
      // R10: reset state
      chk("R10", "frame_n", int'(frame_n), 1);
      chk("R10", "sdata", int'(sdata), 0);
      chk("R10", "tracking", int'(tracking), 1);
      chk("R10", "acquiring", int'(acquiring), 0);
      chk("R10", "eoc", int'(eoc), 0);
      chk("R10", "overrun", int'(overrun), 0);
      chk("R10", "sclk_out idle", int'(sclk_out), 1);

      foreach (VECS[i]) begin
         m   = int'(VECS[i][14:13]);
         idl = VECS[i][12];
         smp = VECS[i][11:0];
         @(negedge clk);
         frame16_sel = VECS[i][14];
         contclk_sel = VECS[i][13];
         idle_high   = idl;
         ext_sclk    = idl;
         repeat (3) @(posedge clk);
         run_conv(smp, -10, n);
         chk("R1", $sformatf("conversion cycles vec %0d", i), n, (m == 0) ? CONV_A : CONV_L);
         chk("R2", "eoc at end of conversion", int'(eoc), 1);
         if (m != 0) begin
            a = 0;
            while (acquiring && a < 1000) begin
               a++;
               chk("R11", "sclk_out idle in external mode", int'(sclk_out), int'(idl));
               @(posedge clk); #1;
               if (a == 1) chk("R2", "eoc single cycle", int'(eoc), 0);
            end
            chk("R2", "acquisition cycles", a, ACQ);
         end
         run_frame(m, idl, smp);
      end

      // R9: start during conversion is ignored, sticky overrun
      @(negedge clk);
      frame16_sel = 1'b0; contclk_sel = 1'b1; idle_high = 1'b1; ext_sclk = 1'b1;
      chk("R9", "overrun clear before test", int'(overrun), 0);
      run_conv(12'h123, 50, n);
      chk("R9", "conversion length with extra start", n, CONV_L);
      chk("R9", "overrun set", int'(overrun), 1);
      run_frame(1, 1'b1, 12'h123);
      chk("R9", "overrun sticky", int'(overrun), 1);

      // R9: start while readout armed is ignored
      @(negedge clk);
      frame16_sel = 1'b1; contclk_sel = 1'b1;
      run_conv(12'h9B4, -10, n);
      repeat (ACQ + 5) @(posedge clk);
      @(negedge clk); sample_in = 12'h000; conv_start = 1'b1;
      repeat (2) @(posedge clk); #1;
      conv_start = 1'b0;
      chk("R9", "tracking kept while armed", int'(tracking), 1);
      run_frame(3, 1'b1, 12'h9B4);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule